// File: doc/BRIEF.md
# SPI Sequencing Master

This block is an SPI bus master that treats a multi-byte exchange as one transaction. A single start pulse carries the total byte count, the number of leading command bytes and a gap length. The master then drives chip select low and keeps it low until every byte has been exchanged. After the command bytes it can hold the serial clock low for a programmable number of clock periods, which gives a slow slave time to act on the command before the payload starts.

Transmit and receive are independent byte streams with valid/ready handshakes. Each byte period takes one byte from the transmit stream if one is offered. If none is offered, it sends an all-ones filler byte instead, so a short command followed by a long read needs only the command bytes queued. Every byte received on the data-in line is delivered on the receive stream. While the receive stream is not ready, the serial clock stops between bytes, so no received byte is lost.

Top module: `spi_seq_master`

## Requirements
- R1: `cs_n` falls on the clock cycle after an accepted start, stays low through every byte, gap and stall of the transaction, and rises at its end. `busy` is high exactly while `cs_n` is low.
- R2: Mode 0 timing. `sclk` idles low. Each `sclk` half-period lasts DIV system clocks. Bits go out MSB first. `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge of `sclk`.
- R3: Full duplex. Every byte position of a transaction yields exactly one byte on the receive stream (`rx_valid`), made of the eight `miso` bits sampled in that byte, with the first sampled bit as bit 7.
- R4: `tx_ready` is a one-cycle pulse at the start of each byte position. If `tx_valid` is high in that cycle, `tx_data` is sent and consumed. Otherwise the byte 0xFF is sent and nothing is consumed.
- R5: When 0 < `cmd_len` < `xfer_len` and `gap_len` > 0, `sclk` is held low for an extra `gap_len`×2×DIV system clocks between byte `cmd_len`-1 and byte `cmd_len`. In every other case no gap is inserted.
- R6: With the receive stream always ready, the first rising `sclk` edge comes DIV+1 clocks after `cs_n` falls, and `cs_n` rises DIV+1 clocks after the last falling `sclk` edge. The whole transaction keeps `cs_n` low for `xfer_len`×(16×DIV+2) + gap clocks + DIV clocks.
- R7: A start pulse while `busy` is high is ignored. A start with `xfer_len` of zero leaves `busy` low and `cs_n` high.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_data` holds steady and `sclk` stays low. The transaction resumes once the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction when idle |
| xfer_len | input | LEN_W | Total bytes in the transaction |
| cmd_len | input | LEN_W | Leading command bytes before the gap |
| gap_len | input | GAP_W | Gap length in whole SCLK periods |
| busy | output | 1 | Transaction in progress |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Receiver accepts byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
At one byte boundary, both the end of the command phase (the gap point) and the end of the transaction can fall due. This happens when `cmd_len` equals or exceeds `xfer_len`. The sweep sets `cmd_len` from zero up to past `xfer_len` for every length, and for each case compares the cycles `cs_n` spends low and the longest quiet stretch of `sclk` with the formulas of R5 and R6. A transaction that wrongly inserts a gap before deasserting shows up as a longer low time. A second collision, filler insertion at the byte where the transmit queue runs dry, is swept by setting every queue depth from empty to full.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_DELIVER,
    ST_GAP,
    ST_TRAIL
  } seq_state_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // Clocks spent in a gap of the given number of SCLK periods.
  function automatic int unsigned gap_span(int unsigned gap, int unsigned div);
    return gap * 2 * div;
  endfunction

  // True when the boundary after byte count 'done' is the command/payload gap.
  function automatic bit gap_after(int unsigned done, int unsigned cmd,
                                   int unsigned total, int unsigned gap);
    return (cmd != 0) && (done == cmd) && (done < total) && (gap != 0);
  endfunction

endpackage

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       sample,
  input  logic       shift,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       last_bit
);
  logic [7:0] tx_q;
  logic [7:0] rx_q;
  logic [2:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      if (load) begin
        tx_q  <= load_byte;
        bit_q <= '0;
      end else if (shift) begin
        tx_q  <= {tx_q[6:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
      if (sample) rx_q <= {rx_q[6:0], miso};
    end
  end

  assign mosi     = tx_q[7];
  assign rx_byte  = rx_q;
  assign last_bit = (bit_q == 3'd7);
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master #(
  parameter int DIV   = 2,
  parameter int LEN_W = 8,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [GAP_W-1:0] gap_len,
  output logic             busy,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  import spi_seq_pkg::*;

  localparam int CNT_W = GAP_W + $clog2(DIV) + 2;
  localparam logic [CNT_W-1:0] HALF_LOAD = CNT_W'(DIV - 1);

  seq_state_t       state_q, state_d;
  logic [LEN_W-1:0] len_q, cmd_q, done_q;
  logic [GAP_W-1:0] gap_q;
  logic [LEN_W-1:0] done_next;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             last_bit;

  // Named internal events, also used by the bound checker.
  logic ev_start, ev_load, ev_rise, ev_fall, ev_accept, in_gap;
  logic last_byte, gap_here;

  assign done_next = done_q + 1'b1;
  assign last_byte = (done_next == len_q);
  assign gap_here  = gap_after(int'(done_next), int'(cmd_q), int'(len_q), int'(gap_q));

  assign ev_start  = (state_q == ST_IDLE) && start && (xfer_len != '0);
  assign ev_load   = (state_q == ST_LOAD);
  assign ev_rise   = (state_q == ST_LOW)  && tmr_done;
  assign ev_fall   = (state_q == ST_HIGH) && tmr_done;
  assign ev_accept = (state_q == ST_DELIVER) && rx_ready;
  assign in_gap    = (state_q == ST_GAP);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = HALF_LOAD;
    unique case (state_q)
      ST_IDLE: if (ev_start) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
      end
      ST_LOW: if (tmr_done) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
      end
      ST_HIGH: if (tmr_done) begin
        if (last_bit) state_d = ST_DELIVER;
        else begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
        end
      end
      ST_DELIVER: if (rx_ready) begin
        if (last_byte) begin
          state_d  = ST_TRAIL;
          tmr_load = 1'b1;
        end else if (gap_here) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(gap_span(int'(gap_q), DIV) - 1);
        end else begin
          state_d  = ST_LOAD;
        end
      end
      ST_GAP:   if (tmr_done) state_d = ST_LOAD;
      ST_TRAIL: if (tmr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cmd_q   <= '0;
      gap_q   <= '0;
      done_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        len_q  <= xfer_len;
        cmd_q  <= cmd_len;
        gap_q  <= gap_len;
        done_q <= '0;
      end else if (ev_accept) begin
        done_q <= done_next;
      end
    end
  end

  spi_seq_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  spi_seq_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_load),
    .load_byte (tx_valid ? tx_data : FILL_BYTE),
    .sample    (ev_rise),
    .shift     (ev_fall && !last_bit),
    .miso      (miso),
    .mosi      (mosi),
    .rx_byte   (rx_data),
    .last_bit  (last_bit)
  );

  assign busy     = (state_q != ST_IDLE);
  assign cs_n     = (state_q == ST_IDLE);
  assign sclk     = (state_q == ST_HIGH);
  assign tx_ready = ev_load;
  assign rx_valid = (state_q == ST_DELIVER);
endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] xfer_len,
  input logic             busy,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [7:0]       rx_data,
  input logic             in_gap
);
  a_r1_cs_under_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  a_r1_cs_under_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && cs_n && !tx_ready && !rx_valid));

  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r3_rx_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(sclk));

  a_r4_tx_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  a_r5_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (!sclk && !cs_n && !rx_valid));

  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && xfer_len == '0) |=> !busy);

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r8_stall_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sclk);
endmodule

bind spi_seq_master spi_seq_checker #(.LEN_W(LEN_W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .xfer_len (xfer_len),
  .busy     (busy),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .in_gap   (in_gap)
);

// File: tb/test_spi_seq_master.sv
`timescale 1ns/1ps
module test_spi_seq_master;
  localparam int DIV   = 2;
  localparam int LEN_W = 8;
  localparam int GAP_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [GAP_W-1:0] gap_len = '0;
  logic busy, tx_ready, rx_valid, sclk, mosi, cs_n;
  logic [7:0] tx_data, rx_data;
  logic tx_valid;
  logic rx_ready = 1'b1;
  logic miso = 1'b0;

  always #5 clk = ~clk;

  spi_seq_master #(.DIV(DIV), .LEN_W(LEN_W), .GAP_W(GAP_W)) i_spi_seq_master (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .cmd_len(cmd_len), .gap_len(gap_len), .busy(busy),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;
  int seed = 0;
  int n_tx = 0;
  bit clr = 1'b0;
  bit stall_mode = 1'b0;
  int cyc = 0;

  function automatic logic [7:0] tx_pat(int k, int s);
    return 8'(k * 29 + s * 7 + 8'h11);
  endfunction
  function automatic logic [7:0] sl_pat(int k, int s);
    return 8'(8'hC3 ^ (k * 53 + s));
  endfunction
  function automatic int gap_clocks(int len, int cmd, int gap);
    if (cmd > 0 && cmd < len && gap > 0) return gap * 2 * DIV;
    return 0;
  endfunction

  // Transmit source: offers n_tx bytes
  int tx_idx = 0;
  always @(posedge clk) begin
    if (clr) tx_idx <= 0;
    else if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;
  end
  assign tx_valid = (tx_idx < n_tx);
  assign tx_data  = tx_pat(tx_idx, seed);

  // Receive sink
  logic [7:0] rx_got [0:15];
  int rx_n = 0;
  always @(posedge clk) begin
    if (clr) rx_n <= 0;
    else if (rx_valid && rx_ready) begin
      if (rx_n < 16) rx_got[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end
  always @(negedge clk) begin
    cyc <= cyc + 1;
    rx_ready <= stall_mode ? (cyc % 4 == 3) : 1'b1;
  end

  // Slave model, mode 0
  logic [7:0] s_sh = 8'h00;
  logic [7:0] m_sh = 8'h00;
  logic [7:0] mosi_got [0:15];
  int s_bit = 0;
  int s_idx = 0;
  always @(negedge cs_n) begin
    s_bit = 0; s_idx = 0;
    s_sh = sl_pat(0, seed);
    miso = s_sh[7];
  end
  always @(posedge sclk) m_sh = {m_sh[6:0], mosi};
  always @(negedge sclk) begin
    s_bit++;
    if (s_bit == 8) begin
      if (s_idx < 16) mosi_got[s_idx] = m_sh;
      s_idx++;
      s_bit = 0;
      s_sh = sl_pat(s_idx, seed);
    end else begin
      s_sh = {s_sh[6:0], 1'b0};
    end
    miso = s_sh[7];
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Run one transaction; poke = issue a second start mid-transaction.
  task automatic run_xfer(int len, int cmd, int gap, int ntx, bit stall, bit poke);
    int low_cnt = 0, lead = 0, run = 0, max_run = 0, trail = 0, rdy = 0, guard = 0;
    bit seen = 0;
    seed++;
    @(negedge clk);
    clr = 1; n_tx = ntx; stall_mode = stall;
    xfer_len = LEN_W'(len); cmd_len = LEN_W'(cmd); gap_len = GAP_W'(gap);
    @(negedge clk);
    clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    while (!cs_n && guard < 5000) begin
      guard++;
      low_cnt++;
      if (!busy) chk(0, "R1 busy low while cs_n low", 0, 1);
      if (tx_ready) rdy++;
      if (sclk) begin
        if (seen && run > max_run) max_run = run;
        seen = 1; run = 0;
      end else begin
        run++;
        if (!seen) lead++;
      end
      if (poke && low_cnt == 10) begin start = 1; xfer_len = LEN_W'(len + 3); end
      if (poke && low_cnt == 11) begin start = 0; xfer_len = LEN_W'(len); end
      @(negedge clk);
    end
    trail = run;
    if (guard >= 5000) chk(0, "R1 transaction did not end", guard, 0);
    chk(busy == 0, "R1 busy released with cs_n", busy, 0);
    repeat (2) @(negedge clk);
    chk(rx_n == len, "R3 receive byte count", rx_n, len);
    chk(s_idx == len, "R2 sclk byte count", s_idx, len);
    chk(rdy == len, "R4 tx_ready pulses", rdy, len);
    chk(tx_idx == ((ntx < len) ? ntx : len), "R4 tx bytes consumed", tx_idx, (ntx < len) ? ntx : len);
    for (int k = 0; k < len && k < 16; k++) begin
      logic [7:0] exp_tx;
      exp_tx = (k < ntx) ? tx_pat(k, seed) : 8'hFF;
      chk(mosi_got[k] == exp_tx, "R2 R4 mosi byte", mosi_got[k], exp_tx);
      chk(rx_got[k] == sl_pat(k, seed), "R3 rx byte", rx_got[k], sl_pat(k, seed));
    end
    if (!stall) begin
      int exp_low;
      exp_low = len * (16 * DIV + 2) + gap_clocks(len, cmd, gap) + DIV;
      chk(low_cnt == exp_low, "R6 R5 R7 cs_n low duration", low_cnt, exp_low);
      chk(lead == DIV + 1, "R6 lead time", lead, DIV + 1);
      chk(trail == DIV + 1, "R6 trail time", trail, DIV + 1);
      if (len >= 2)
        chk(max_run == gap_clocks(len, cmd, gap) + DIV + 2, "R5 longest sclk quiet",
            max_run, gap_clocks(len, cmd, gap) + DIV + 2);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1, "R1 reset cs_n", cs_n, 1);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(sclk == 0, "R2 reset sclk", sclk, 0);
    chk(tx_ready == 0 && rx_valid == 0, "R4 reset handshakes", {tx_ready, rx_valid}, 0);

    // R7: zero length
    xfer_len = '0; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 5; i++) begin
      chk(busy == 0 && cs_n == 1, "R7 zero length stays idle", {busy, cs_n}, 1);
      @(negedge clk);
    end

    // Sweep: lengths, command counts (past the end), gaps, queue depths
    for (int len = 1; len <= 4; len++)
      for (int cmd = 0; cmd <= len + 1; cmd++)
        for (int gap = 0; gap <= 2; gap++)
          for (int ntx = 0; ntx <= len; ntx++)
            run_xfer(len, cmd, gap, ntx, 1'b0, 1'b0);

    // R8: receive stall
    run_xfer(5, 2, 1, 3, 1'b1, 1'b0);
    run_xfer(3, 0, 0, 0, 1'b1, 1'b0);
    // R7: start while busy ignored
    run_xfer(3, 1, 1, 2, 1'b0, 1'b1);
    run_xfer(6, 2, 3, 6, 1'b0, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule